// File: doc/BRIEF.md
# SPI Word Queue and Threshold Status Unit

This unit sits between a register-side producer/consumer and a serial shift engine. It holds up to four outgoing words and up to four incoming words, reports how full each queue is, and raises status when a queue crosses a programmable level. When queue mode is on, it hands outgoing words to the engine one at a time over a valid/accept handshake. It takes returned words from the engine on a valid strobe, and it keeps a busy indication high for as long as work remains.

The receive side flags an overrun when a word arrives with no room left; that word is discarded. It also flags a time-out when received data sits unread for too long. The limit is counted in serial-clock periods when the unit is bus master and in core clock cycles when it is a bus slave. Each queue can be emptied by a one-shot clear command that cancels itself. A single interrupt line combines the four status sources through individual enables.

Top module: `spi_qb_top`

## Requirements
- R1: After reset both counts are 0, both empty flags are 1, both full flags, busy, overrun, time-out, the clear-pending bits, engine valid and the interrupt are 0; an empty flag is 1 exactly when its count is 0 and a full flag is 1 exactly when its count equals the depth (4).
- R2: A write to a full transmit queue and a read of an empty receive queue change nothing: the counts and the data already held stay as they were.
- R3: Words leave each queue in the order they entered; the head of the receive queue is visible on `rx_rd_data` before it is read.
- R4: With queue mode on, `busy` is 1 whenever the transmit queue is non-empty or a word handed to the engine has not yet come back. It goes to 0 in the cycle after the last word returns. With queue mode off, `busy` is 0 and no word is offered to the engine.
- R5: `rx_thr_sts` is 1 exactly when the receive count is strictly greater than `cfg_rx_thr`.
- R6: `tx_thr_sts` is 1 exactly when the transmit count is less than or equal to `cfg_tx_thr`.
- R7: A word that arrives while the receive queue is full is discarded, and the queue keeps its earlier contents. `ovr_flag` is set and stays set until a cycle with `sw_ovr_w1c` high and no new overrun.
- R8: In master mode (`cfg_slave_mode` = 0), `tmo_flag` rises on the 64th `sclk_tick` counted while the receive queue is non-empty and unread.
- R9: In slave mode, `tmo_flag` rises on the 576th core clock edge after the receive queue becomes non-empty, provided no read occurs in that time.
- R10: A receive read or `sw_tmo_w1c` clears `tmo_flag` and restarts the time-out count from zero.
- R11: A clear request sets its pending bit for exactly one cycle. At the following edge that queue's count becomes 0 and the pending bit drops, and a write or arrival offered in that cycle is discarded.
- R12: `irq` equals, one cycle later, the OR of receive-threshold, transmit-threshold, overrun and time-out status, each ANDed with its own enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | Queue mode enable |
| cfg_slave_mode | input | 1 | 1 = bus slave, 0 = bus master |
| cfg_rx_thr | input | THR_W | Receive threshold level |
| cfg_tx_thr | input | THR_W | Transmit threshold level |
| en_rx_thr | input | 1 | Interrupt enable, receive threshold |
| en_tx_thr | input | 1 | Interrupt enable, transmit threshold |
| en_ovr | input | 1 | Interrupt enable, overrun |
| en_tmo | input | 1 | Interrupt enable, time-out |
| sw_tx_wr | input | 1 | Push a word into the transmit queue |
| sw_tx_data | input | DW | Word to push |
| sw_rx_rd | input | 1 | Pop the receive queue head |
| rx_rd_data | output | DW | Receive queue head |
| sw_tx_flush_req | input | 1 | Request to empty the transmit queue |
| sw_rx_flush_req | input | 1 | Request to empty the receive queue |
| sw_ovr_w1c | input | 1 | Clear overrun flag |
| sw_tmo_w1c | input | 1 | Clear time-out flag |
| sclk_tick | input | 1 | One pulse per serial clock period |
| eng_tx_valid | output | 1 | A word is offered to the engine |
| eng_tx_data | output | DW | Offered word |
| eng_tx_accept | input | 1 | Engine takes the offered word |
| eng_rx_valid | input | 1 | Engine returns a received word |
| eng_rx_data | input | DW | Returned word |
| tx_count | output | CNT_W | Transmit occupancy |
| rx_count | output | CNT_W | Receive occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_thr_sts | output | 1 | Transmit threshold status |
| rx_thr_sts | output | 1 | Receive threshold status |
| ovr_flag | output | 1 | Sticky receive overrun |
| tmo_flag | output | 1 | Receive time-out |
| busy | output | 1 | Work outstanding in queue mode |
| tx_flush_pending | output | 1 | Transmit clear in progress |
| rx_flush_pending | output | 1 | Receive clear in progress |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume that the engine raises `eng_tx_accept` only as a response to an offered word, and returns at most one word per cycle on `eng_rx_valid`. They also assume that the clear requests and write-one-clear strobes are single-cycle pulses. The stimulus drives every input for exactly one cycle per action and models the engine as taking one word, then returning one word a few cycles later. The stimulus never overlaps a clear request with a pending clear, and it holds `sclk_tick` low except during the master time-out scenario, so no time-out fires unintentionally.

// File: rtl/spi_qb_pkg.sv
package spi_qb_pkg;

  typedef struct packed {
    logic rx_thr;
    logic tx_thr;
    logic ovr;
    logic tmo;
  } irq_src_t;

  localparam int unsigned TMO_MASTER_DEF = 64;
  localparam int unsigned TMO_SLAVE_DEF  = 576;

  function automatic logic irq_any(input irq_src_t src, input irq_src_t en);
    return |(src & en);
  endfunction

endpackage

// File: rtl/spi_qb_fifo.sv
module spi_qb_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rptr];
  assign count = cnt;
endmodule

// File: rtl/spi_qb_rxtmo.sv
module spi_qb_rxtmo #(
  parameter int MLIM = 64,
  parameter int SLIM = 576
) (
  input  logic clk,
  input  logic rst,
  input  logic slave_mode,
  input  logic sclk_tick,
  input  logic rx_empty,
  input  logic rx_pop,
  input  logic w1c,
  output logic tmo_flag
);
  localparam int LMAX = (MLIM > SLIM) ? MLIM : SLIM;
  localparam int CW   = $clog2(LMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          ev;
  logic          restart;

  assign lim     = slave_mode ? CW'(SLIM - 1) : CW'(MLIM - 1);
  assign ev      = slave_mode | sclk_tick;
  assign restart = rx_empty | rx_pop | w1c;

  always_ff @(posedge clk) begin
    if (rst || restart)          cnt <= '0;
    else if (ev && cnt != lim)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                     tmo_flag <= 1'b0;
    else if (rx_pop || w1c)      tmo_flag <= 1'b0;
    else if (!rx_empty && ev && cnt == lim) tmo_flag <= 1'b1;
  end
endmodule

// File: rtl/spi_qb_top.sv
module spi_qb_top
  import spi_qb_pkg::*;
#(
  parameter int DW         = 32,
  parameter int DEPTH      = 4,
  parameter int CNT_W      = 4,
  parameter int THR_W      = 2,
  parameter int TMO_MASTER = TMO_MASTER_DEF,
  parameter int TMO_SLAVE  = TMO_SLAVE_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_fifo_en,
  input  logic             cfg_slave_mode,
  input  logic [THR_W-1:0] cfg_rx_thr,
  input  logic [THR_W-1:0] cfg_tx_thr,
  input  logic             en_rx_thr,
  input  logic             en_tx_thr,
  input  logic             en_ovr,
  input  logic             en_tmo,
  input  logic             sw_tx_wr,
  input  logic [DW-1:0]    sw_tx_data,
  input  logic             sw_rx_rd,
  output logic [DW-1:0]    rx_rd_data,
  input  logic             sw_tx_flush_req,
  input  logic             sw_rx_flush_req,
  input  logic             sw_ovr_w1c,
  input  logic             sw_tmo_w1c,
  input  logic             sclk_tick,
  output logic             eng_tx_valid,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_tx_accept,
  input  logic             eng_rx_valid,
  input  logic [DW-1:0]    eng_rx_data,
  output logic [CNT_W-1:0] tx_count,
  output logic [CNT_W-1:0] rx_count,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             tx_thr_sts,
  output logic             rx_thr_sts,
  output logic             ovr_flag,
  output logic             tmo_flag,
  output logic             busy,
  output logic             tx_flush_pending,
  output logic             rx_flush_pending,
  output logic             irq
);
  localparam int PAD = CNT_W - THR_W;

  logic     tx_flush_q, rx_flush_q;
  logic     inflight_q;
  logic     ovr_q;
  logic     irq_q;
  logic     tx_pop, rx_pop_eff;
  irq_src_t src, ena;

  // one-shot clear commands: pending for one cycle, then self-cleared
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= ~tx_flush_q & sw_tx_flush_req;
      rx_flush_q <= ~rx_flush_q & sw_rx_flush_req;
    end
  end

  spi_qb_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .flush (tx_flush_q),
    .push  (sw_tx_wr),
    .wdata (sw_tx_data),
    .pop   (tx_pop),
    .rdata (eng_tx_data),
    .count (tx_count),
    .empty (tx_empty),
    .full  (tx_full)
  );

  spi_qb_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (rx_flush_q),
    .push  (eng_rx_valid),
    .wdata (eng_rx_data),
    .pop   (sw_rx_rd),
    .rdata (rx_rd_data),
    .count (rx_count),
    .empty (rx_empty),
    .full  (rx_full)
  );

  // engine handshake: one word outstanding at a time
  assign eng_tx_valid = cfg_fifo_en & ~tx_empty & ~inflight_q & ~tx_flush_q;
  assign tx_pop       = eng_tx_valid & eng_tx_accept;
  assign rx_pop_eff   = sw_rx_rd & ~rx_empty & ~rx_flush_q;

  always_ff @(posedge clk) begin
    if (rst)               inflight_q <= 1'b0;
    else if (tx_pop)       inflight_q <= 1'b1;
    else if (eng_rx_valid) inflight_q <= 1'b0;
  end

  assign busy = cfg_fifo_en & (~tx_empty | inflight_q);

  // overrun: set has priority over the clear strobe
  always_ff @(posedge clk) begin
    if (rst)                          ovr_q <= 1'b0;
    else if (eng_rx_valid && rx_full) ovr_q <= 1'b1;
    else if (sw_ovr_w1c)              ovr_q <= 1'b0;
  end

  spi_qb_rxtmo #(.MLIM(TMO_MASTER), .SLIM(TMO_SLAVE)) u_tmo (
    .clk        (clk),
    .rst        (rst),
    .slave_mode (cfg_slave_mode),
    .sclk_tick  (sclk_tick),
    .rx_empty   (rx_empty),
    .rx_pop     (rx_pop_eff),
    .w1c        (sw_tmo_w1c),
    .tmo_flag   (tmo_flag)
  );

  assign rx_thr_sts = rx_count >  {{PAD{1'b0}}, cfg_rx_thr};
  assign tx_thr_sts = tx_count <= {{PAD{1'b0}}, cfg_tx_thr};

  assign src = '{rx_thr: rx_thr_sts, tx_thr: tx_thr_sts, ovr: ovr_q, tmo: tmo_flag};
  assign ena = '{rx_thr: en_rx_thr, tx_thr: en_tx_thr, ovr: en_ovr, tmo: en_tmo};

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_any(src, ena);
  end

  assign ovr_flag         = ovr_q;
  assign irq              = irq_q;
  assign tx_flush_pending = tx_flush_q;
  assign rx_flush_pending = rx_flush_q;
endmodule

// File: rtl/spi_qb_chk.sv
module spi_qb_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_fifo_en,
  input logic             sw_tx_wr,
  input logic             sw_rx_rd,
  input logic             sw_ovr_w1c,
  input logic             eng_tx_accept,
  input logic             eng_rx_valid,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             tx_empty,
  input logic             tx_full,
  input logic             rx_empty,
  input logic             rx_full,
  input logic             ovr_flag,
  input logic             tmo_flag,
  input logic             busy,
  input logic             tx_flush_pending,
  input logic             rx_flush_pending
);
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

  a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (sw_tx_wr && tx_full && !eng_tx_accept && !tx_flush_pending) |=> (tx_count == CNT_W'(DEPTH)));

  a_r4_busy_with_data: assert property (@(posedge clk) disable iff (rst)
    (cfg_fifo_en && !tx_empty) |-> busy);

  a_r4_busy_fall_empty: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (tx_empty || !cfg_fifo_en));

  a_r7_drop_on_full: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_valid && rx_full && !sw_rx_rd && !rx_flush_pending) |=> (rx_count == CNT_W'(DEPTH) && ovr_flag));

  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !sw_ovr_w1c) |=> ovr_flag);

  a_r10_read_clears_tmo: assert property (@(posedge clk) disable iff (rst)
    (sw_rx_rd && !rx_empty && !rx_flush_pending) |=> !tmo_flag);

  a_r11_rx_flush: assert property (@(posedge clk) disable iff (rst)
    rx_flush_pending |=> (rx_count == '0 && !rx_flush_pending));

  a_r11_tx_flush: assert property (@(posedge clk) disable iff (rst)
    tx_flush_pending |=> (tx_count == '0 && !tx_flush_pending));
endmodule

bind spi_qb_top spi_qb_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/spi_qb_top_tb.sv
module spi_qb_top_tb;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int CNT_W = 4;
  localparam int THR_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_fifo_en = 0, cfg_slave_mode = 0;
  logic [THR_W-1:0] cfg_rx_thr = '0, cfg_tx_thr = '0;
  logic en_rx_thr = 0, en_tx_thr = 0, en_ovr = 0, en_tmo = 0;
  logic sw_tx_wr = 0, sw_rx_rd = 0;
  logic [DW-1:0] sw_tx_data = '0;
  logic sw_tx_flush_req = 0, sw_rx_flush_req = 0, sw_ovr_w1c = 0, sw_tmo_w1c = 0;
  logic sclk_tick = 0, eng_tx_accept = 0, eng_rx_valid = 0;
  logic [DW-1:0] eng_rx_data = '0;
  logic [DW-1:0] rx_rd_data, eng_tx_data;
  logic eng_tx_valid;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic tx_empty, tx_full, rx_empty, rx_full, tx_thr_sts, rx_thr_sts;
  logic ovr_flag, tmo_flag, busy, tx_flush_pending, rx_flush_pending, irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_qb_top #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_dut (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [DW-1:0] d);
    sw_tx_wr = 1; sw_tx_data = d; step(); sw_tx_wr = 0;
  endtask

  task automatic arrive(input logic [DW-1:0] d);
    eng_rx_valid = 1; eng_rx_data = d; step(); eng_rx_valid = 0;
  endtask

  task automatic pop_rx(output logic [DW-1:0] d);
    d = rx_rd_data; sw_rx_rd = 1; step(); sw_rx_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_count", 32'(tx_count), 0);
    chk("R1 rx_count", 32'(rx_count), 0);
    chk("R1 empties", {tx_empty, rx_empty}, 2'b11);
    chk("R1 fulls", {tx_full, rx_full}, 2'b00);
    chk("R1 busy/ovr/tmo/irq", {busy, ovr_flag, tmo_flag, irq, eng_tx_valid}, 5'b0);
    chk("R1 pending", {tx_flush_pending, rx_flush_pending}, 2'b00);
  endtask

  task automatic t_tx_path();
    logic [DW-1:0] d;
    cfg_fifo_en = 0; cfg_tx_thr = 2'd3;
    for (int i = 0; i < 5; i++) begin
      push_tx(32'hA000 + i);
      if (i < 4) begin
        chk("R1 tx count", 32'(tx_count), i + 1);
        chk("R6 tx thr", 32'(tx_thr_sts), (i + 1 <= 3) ? 1 : 0);
      end
    end
    chk("R2 write to full ignored", 32'(tx_count), 4);
    chk("R1 tx_full", 32'(tx_full), 1);
    chk("R4 no offer when mode off", {busy, eng_tx_valid}, 2'b00);
    cfg_fifo_en = 1; #1;
    chk("R4 busy with data", 32'(busy), 1);
    for (int k = 0; k < 4; k++) begin
      chk("R3 tx valid", 32'(eng_tx_valid), 1);
      chk("R3 tx order", eng_tx_data, 32'hA000 + k);
      eng_tx_accept = 1; step(); eng_tx_accept = 0;
      chk("R4 busy in flight", 32'(busy), 1);
      step(); step();
      arrive((32'hA000 + k) ^ 32'h5555_0000);
      if (k == 3) chk("R4 busy falls after last", 32'(busy), 0);
    end
    chk("R3 rx count after drain", 32'(rx_count), 4);
    cfg_rx_thr = 2'd1; #1;
    chk("R5 rx thr at 4", 32'(rx_thr_sts), 1);
    for (int k = 0; k < 4; k++) begin
      pop_rx(d);
      chk("R3 rx order", d, (32'hA000 + k) ^ 32'h5555_0000);
      chk("R5 rx thr", 32'(rx_thr_sts), (3 - k > 1) ? 1 : 0);
    end
    chk("R1 rx empty", 32'(rx_empty), 1);
    sw_rx_rd = 1; step(); sw_rx_rd = 0;
    chk("R2 pop empty ignored", {28'd0, rx_count}, 0);
    cfg_fifo_en = 0; #1;
    chk("R4 busy off", 32'(busy), 0);
    cfg_tx_thr = 2'd0; #1;
    chk("R6 tx thr empty", 32'(tx_thr_sts), 1);
  endtask

  task automatic t_rx_ovr();
    logic [DW-1:0] d;
    en_ovr = 1;
    for (int i = 0; i < 5; i++) begin
      arrive(32'hB000 + i);
      if (i == 3) chk("R7 no ovr at full", {rx_full, ovr_flag}, 2'b10);
    end
    chk("R7 ovr set", 32'(ovr_flag), 1);
    chk("R7 count kept", 32'(rx_count), 4);
    step();
    chk("R12 irq ovr", 32'(irq), 1);
    for (int k = 0; k < 4; k++) begin
      pop_rx(d);
      chk("R7 contents kept", d, 32'hB000 + k);
    end
    chk("R7 sticky", 32'(ovr_flag), 1);
    sw_ovr_w1c = 1; step(); sw_ovr_w1c = 0;
    chk("R7 w1c clears", 32'(ovr_flag), 0);
    step();
    chk("R12 irq drops", 32'(irq), 0);
    en_ovr = 0;
  endtask

  task automatic t_tmo_master();
    logic [DW-1:0] d;
    cfg_slave_mode = 0; en_tmo = 1;
    arrive(32'hC000);
    for (int i = 0; i < 63; i++) begin
      sclk_tick = 1; step(); sclk_tick = 0; step(); step(); step();
    end
    chk("R8 no tmo at 63", 32'(tmo_flag), 0);
    sclk_tick = 1; step(); sclk_tick = 0;
    chk("R8 tmo at 64", 32'(tmo_flag), 1);
    step();
    chk("R12 irq tmo", 32'(irq), 1);
    pop_rx(d);
    chk("R10 read clears tmo", 32'(tmo_flag), 0);
    step();
    chk("R12 irq tmo gone", 32'(irq), 0);
    en_tmo = 0;
  endtask

  task automatic t_tmo_slave();
    logic [DW-1:0] d;
    cfg_slave_mode = 1;
    arrive(32'hD000);
    repeat (575) step();
    chk("R9 no tmo at 575", 32'(tmo_flag), 0);
    step();
    chk("R9 tmo at 576", 32'(tmo_flag), 1);
    sw_tmo_w1c = 1; step(); sw_tmo_w1c = 0;
    chk("R10 w1c clears tmo", 32'(tmo_flag), 0);
    repeat (575) step();
    chk("R10 restarted count", 32'(tmo_flag), 0);
    step();
    chk("R10 refires at 576", 32'(tmo_flag), 1);
    pop_rx(d);
    chk("R10 read clears", 32'(tmo_flag), 0);
    cfg_slave_mode = 0;
  endtask

  task automatic t_flush();
    cfg_fifo_en = 0;
    push_tx(32'hE000); push_tx(32'hE001); push_tx(32'hE002);
    sw_tx_flush_req = 1; step(); sw_tx_flush_req = 0;
    chk("R11 tx pending", {tx_flush_pending, 28'd0, tx_count}, {1'b1, 28'd0, 4'd3});
    sw_tx_wr = 1; sw_tx_data = 32'hEEEE; step(); sw_tx_wr = 0;
    chk("R11 tx cleared", {tx_flush_pending, 28'd0, tx_count}, 33'd0);
    push_tx(32'hF000);
    cfg_fifo_en = 1; #1;
    chk("R11 head after clear", eng_tx_data, 32'hF000);
    sw_tx_flush_req = 1; step(); sw_tx_flush_req = 0;
    step();
    cfg_fifo_en = 0;
    arrive(32'h1111); arrive(32'h2222);
    sw_rx_flush_req = 1; step(); sw_rx_flush_req = 0;
    chk("R11 rx pending", 32'(rx_flush_pending), 1);
    eng_rx_valid = 1; eng_rx_data = 32'h3333; step(); eng_rx_valid = 0;
    chk("R11 rx cleared", {rx_flush_pending, 28'd0, rx_count}, 33'd0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst = 0;
    step();
    t_reset();
    t_tx_path();
    t_rx_ovr();
    t_tmo_master();
    t_tmo_slave();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule